// File: doc/BRIEF.md
# Temperature Alarm Event Controller

This block turns a stream of digital temperature samples into a single active-low alarm line, intended to drive an open-drain event pin. Each sample arrives with a one-cycle valid strobe and is compared against three programmable limits: an upper window limit, a lower window limit and a critical limit. Releasing an out-of-limit condition is delayed by a selectable hysteresis band, so a reading that hovers near a limit does not make the line chatter.

Three behaviours are selectable. In latched (interrupt) mode, a window violation is held until software pulses a clear. In comparator mode, the line simply follows the window state and ignores the clear. In critical-only mode, the window is ignored. In every mode, a reading above the critical limit sets a lock. The lock behaves like a comparator: the clear strobe cannot remove it, and it releases only when the temperature drops below the critical limit minus the hysteresis. A global enable gates the output line without disturbing any internal state.

Top module: `tae_event_ctrl`

## Requirements
- R1: While reset is asserted, and directly after it, `event_n` is 1 and every alarm flag, the critical lock and the latch are clear.
- R2: The over-limit flag sets on a valid sample with temperature > `lim_hi`. It clears on a valid sample with temperature < `lim_hi` − H, and otherwise holds. H is taken from `hyst_sel`: 0 = none, 1 = 1.5 °C, 2 = 3 °C, 3 = 6 °C, in LSBs of 2^−FRAC_BITS °C. All comparisons are two's-complement.
- R3: The under-limit flag sets on a valid sample with temperature < `lim_lo`. It clears on a valid sample with temperature > `lim_lo` + H, and otherwise holds.
- R4: In comparator mode (`mode_sel` = 01), the line is active when `win_en` is 1 and either window flag is set, or when the critical lock is set. `sw_clr` has no effect in this mode.
- R5: In latched mode (`mode_sel` = 00), a valid sample that leaves either window flag set while `win_en` is 1 sets a latch. The latch holds until `sw_clr` is pulsed. A set and a clear in the same cycle leave the latch set. The line is active when the latch or the critical lock is set. The latch is cleared while the mode is anything other than 00.
- R6: In critical-only mode (`mode_sel` = 10 or 11), the line is active only when the critical lock is set. Window flags have no effect.
- R7: The critical lock sets on a valid sample with temperature > `lim_crit`. It releases on a valid sample with temperature < `lim_crit` − H. It is immune to `sw_clr` and drives the line in every mode.
- R8: When `evt_en` is 0, `event_n` is forced to 1. The critical lock is not erased, so it shows again when `evt_en` returns to 1, without a new sample.
- R9: Without a valid strobe or a clear pulse, and with the configuration held, `event_n` does not change, even if the temperature input moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | One-cycle strobe: `smp_temp` holds a new reading |
| smp_temp | input | TEMP_W | Signed temperature, 2^−FRAC_BITS °C per LSB |
| lim_hi | input | TEMP_W | Upper window limit, signed |
| lim_lo | input | TEMP_W | Lower window limit, signed |
| lim_crit | input | TEMP_W | Critical limit, signed |
| hyst_sel | input | 2 | Hysteresis code: 0, 1.5, 3 or 6 °C |
| mode_sel | input | 2 | 00 latched, 01 comparator, 1x critical-only |
| win_en | input | 1 | Window alarm enable |
| evt_en | input | 1 | Global output enable |
| sw_clr | input | 1 | Software clear pulse for the latch |
| event_n | output | 1 | Active-low alarm line (drive 0 = asserted) |

## Verification
The bench builds the block with TEMP_W = 9 and FRAC_BITS = 4. This shrinks the reading to 512 codes (−16 to +15.9375 °C), while the hysteresis steps stay 24, 48 and 96 LSBs. That makes it possible to ramp every code up and back down under all four modes and all four hysteresis settings. Every set, hold and release boundary of the three limits is therefore crossed in both directions. Directed steps then cover the clear-versus-set collision, the enable gating with the lock kept, and a moving input with no strobe.

// File: rtl/tae_pkg.sv
package tae_pkg;

  typedef enum logic [1:0] {
    TAE_MODE_LATCH = 2'b00,
    TAE_MODE_CMP   = 2'b01,
    TAE_MODE_CRIT  = 2'b10,
    TAE_MODE_CRIT2 = 2'b11
  } tae_mode_e;

  // Hysteresis band in LSBs for a given code and number of fraction bits.
  function automatic int unsigned tae_hyst_lsb(input logic [1:0] code, input int unsigned frac);
    int unsigned r;
    case (code)
      2'd0:    r = 0;
      2'd1:    r = 3 << (frac - 1);
      2'd2:    r = 3 << frac;
      default: r = 6 << frac;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/tae_rst_sync.sv
module tae_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/tae_hyst_offset.sv
module tae_hyst_offset #(
  parameter int unsigned TEMP_W    = 13,
  parameter int unsigned FRAC_BITS = 4
) (
  input  logic [1:0]      hyst_sel,
  output logic [TEMP_W:0] hyst_off
);
  import tae_pkg::*;

  localparam int unsigned OW = TEMP_W + 1;

  always_comb begin
    hyst_off = OW'(tae_hyst_lsb(hyst_sel, FRAC_BITS));
  end
endmodule

// File: rtl/tae_limit_track.sv
// Tracks one limit condition with hysteresis on release.
// ABOVE=1: condition is "reading above limit"; ABOVE=0: "reading below limit".
module tae_limit_track #(
  parameter int unsigned TEMP_W = 13,
  parameter bit          ABOVE  = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_valid,
  input  logic signed [TEMP_W-1:0] temp,
  input  logic signed [TEMP_W-1:0] limit,
  input  logic        [TEMP_W:0]   hyst_off,
  output logic                     flag_nxt,
  output logic                     flag_q
);
  localparam int unsigned XW = TEMP_W + 1;

  logic signed [XW-1:0] t_x;
  logic signed [XW-1:0] l_x;
  logic signed [XW-1:0] h_x;
  logic                 trip;
  logic                 rel;

  assign t_x = {temp[TEMP_W-1], temp};
  assign l_x = {limit[TEMP_W-1], limit};
  assign h_x = signed'(hyst_off);

  generate
    if (ABOVE) begin : g_above
      always_comb begin
        trip = t_x > l_x;
        rel  = t_x < (l_x - h_x);
      end
    end else begin : g_below
      always_comb begin
        trip = t_x < l_x;
        rel  = t_x > (l_x + h_x);
      end
    end
  endgenerate

  always_comb begin
    flag_nxt = trip | (flag_q & ~rel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flag_q <= 1'b0;
    else if (smp_valid) flag_q <= flag_nxt;
  end
endmodule

// File: rtl/tae_event_mux.sv
module tae_event_mux (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_sel,
  input  logic       win_en,
  input  logic       evt_en,
  input  logic       sw_clr,
  input  logic       smp_valid,
  input  logic       over_nxt,
  input  logic       under_nxt,
  input  logic       over_q,
  input  logic       under_q,
  input  logic       crit_q,
  output logic       pend_q,
  output logic       event_n
);
  import tae_pkg::*;

  tae_mode_e mode;
  logic      is_latch;
  logic      pend_nxt;
  logic      pend_en;
  logic      active;

  assign mode     = tae_mode_e'(mode_sel);
  assign is_latch = (mode == TAE_MODE_LATCH);

  always_comb begin
    pend_en  = smp_valid | sw_clr | ~is_latch;
    pend_nxt = is_latch &
               ((pend_q & ~sw_clr) | (smp_valid & win_en & (over_nxt | under_nxt)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_nxt;
  end

  always_comb begin
    case (mode)
      TAE_MODE_LATCH: active = pend_q | crit_q;
      TAE_MODE_CMP:   active = (win_en & (over_q | under_q)) | crit_q;
      default:        active = crit_q;
    endcase
    event_n = ~(evt_en & active);
  end
endmodule

// File: rtl/tae_event_ctrl.sv
module tae_event_ctrl #(
  parameter int unsigned TEMP_W    = 13,
  parameter int unsigned FRAC_BITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [TEMP_W-1:0] smp_temp,
  input  logic [TEMP_W-1:0] lim_hi,
  input  logic [TEMP_W-1:0] lim_lo,
  input  logic [TEMP_W-1:0] lim_crit,
  input  logic [1:0]        hyst_sel,
  input  logic [1:0]        mode_sel,
  input  logic              win_en,
  input  logic              evt_en,
  input  logic              sw_clr,
  output logic              event_n
);
  logic              rst_n_i;
  logic [TEMP_W:0]   hyst_off;
  logic              over_nxt, over_q;
  logic              under_nxt, under_q;
  logic              crit_nxt, crit_q;
  logic              pend_q;

  tae_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i));

  tae_hyst_offset #(.TEMP_W(TEMP_W), .FRAC_BITS(FRAC_BITS)) u_hyst (
    .hyst_sel(hyst_sel), .hyst_off(hyst_off));

  tae_limit_track #(.TEMP_W(TEMP_W), .ABOVE(1'b1)) u_over (
    .clk(clk), .rst_n(rst_n_i), .smp_valid(smp_valid),
    .temp(signed'(smp_temp)), .limit(signed'(lim_hi)), .hyst_off(hyst_off),
    .flag_nxt(over_nxt), .flag_q(over_q));

  tae_limit_track #(.TEMP_W(TEMP_W), .ABOVE(1'b0)) u_under (
    .clk(clk), .rst_n(rst_n_i), .smp_valid(smp_valid),
    .temp(signed'(smp_temp)), .limit(signed'(lim_lo)), .hyst_off(hyst_off),
    .flag_nxt(under_nxt), .flag_q(under_q));

  tae_limit_track #(.TEMP_W(TEMP_W), .ABOVE(1'b1)) u_crit (
    .clk(clk), .rst_n(rst_n_i), .smp_valid(smp_valid),
    .temp(signed'(smp_temp)), .limit(signed'(lim_crit)), .hyst_off(hyst_off),
    .flag_nxt(crit_nxt), .flag_q(crit_q));

  tae_event_mux u_mux (
    .clk(clk), .rst_n(rst_n_i), .mode_sel(mode_sel), .win_en(win_en),
    .evt_en(evt_en), .sw_clr(sw_clr), .smp_valid(smp_valid),
    .over_nxt(over_nxt), .under_nxt(under_nxt),
    .over_q(over_q), .under_q(under_q), .crit_q(crit_q),
    .pend_q(pend_q), .event_n(event_n));

  logic unused_crit_nxt;
  assign unused_crit_nxt = crit_nxt;
endmodule

// File: rtl/tae_event_ctrl_chk.sv
module tae_event_ctrl_chk #(
  parameter int unsigned TEMP_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_valid,
  input logic [TEMP_W-1:0] smp_temp,
  input logic [TEMP_W-1:0] lim_hi,
  input logic [TEMP_W-1:0] lim_crit,
  input logic [1:0]        hyst_sel,
  input logic [1:0]        mode_sel,
  input logic              win_en,
  input logic              evt_en,
  input logic              sw_clr,
  input logic              event_n,
  input logic              over_q,
  input logic              crit_q,
  input logic              pend_q
);
  always_comb begin
    if (!rst_n) assert_reset_idle_R1: assert (event_n && !crit_q && !pend_q && !over_q);
  end

  assert_over_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && ($signed(smp_temp) > $signed(lim_hi))) |=> over_q);

  assert_latch_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !sw_clr && mode_sel == 2'b00) |=> pend_q);

  assert_crit_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && ($signed(smp_temp) > $signed(lim_crit))) |=> crit_q);

  assert_crit_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (crit_q && !smp_valid) |=> crit_q);

  assert_crit_drives_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (crit_q && evt_en) |-> !event_n);

  assert_gate_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_en |-> event_n);

  assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(smp_valid) && !$past(sw_clr) && $stable(mode_sel) && $stable(win_en)
     && $stable(evt_en) && $stable(hyst_sel)) |-> $stable(event_n));
endmodule

bind tae_event_ctrl tae_event_ctrl_chk #(.TEMP_W(TEMP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_temp(smp_temp),
  .lim_hi(lim_hi), .lim_crit(lim_crit), .hyst_sel(hyst_sel),
  .mode_sel(mode_sel), .win_en(win_en), .evt_en(evt_en), .sw_clr(sw_clr),
  .event_n(event_n), .over_q(over_q), .crit_q(crit_q), .pend_q(pend_q));

// File: tb/tae_event_ctrl_test.sv
module tae_event_ctrl_test;
  localparam int W     = 9;
  localparam int F     = 4;
  localparam int TCLK  = 10;
  localparam int HI    = 64;
  localparam int LO    = -64;
  localparam int CRIT  = 160;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         smp_valid, win_en, evt_en, sw_clr;
  logic [W-1:0] smp_temp, lim_hi, lim_lo, lim_crit;
  logic [1:0]   hyst_sel, mode_sel;
  logic         event_n;

  int n_chk = 0;
  int n_fail = 0;

  // bench model state
  bit m_ovr, m_und, m_crt, m_pend;

  always #(TCLK/2) clk = ~clk;

  tae_event_ctrl #(.TEMP_W(W), .FRAC_BITS(F)) uut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_temp(smp_temp),
    .lim_hi(lim_hi), .lim_lo(lim_lo), .lim_crit(lim_crit),
    .hyst_sel(hyst_sel), .mode_sel(mode_sel), .win_en(win_en),
    .evt_en(evt_en), .sw_clr(sw_clr), .event_n(event_n));

  function automatic int hys_of(input logic [1:0] c);
    case (c)
      2'd0: return 0;
      2'd1: return 24;
      2'd2: return 48;
      default: return 96;
    endcase
  endfunction

  function automatic bit exp_line();
    bit act;
    if (mode_sel == 2'b00)      act = m_pend || m_crt;
    else if (mode_sel == 2'b01) act = (win_en && (m_ovr || m_und)) || m_crt;
    else                        act = m_crt;
    return !(evt_en && act);
  endfunction

  task automatic check(input string tag, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: event_n=%0b expected %0b (mode=%0d hyst=%0d temp=%0d)",
               tag, got, exp, mode_sel, hyst_sel, $signed(smp_temp));
    end
  endtask

  // one clock step: drive at negedge, model update after posedge, check at negedge
  task automatic step(input bit v, input int t, input bit clr, input string tag);
    int h;
    bit o, u, c, p, wo;
    smp_valid = v;
    smp_temp  = W'(t);
    sw_clr    = clr;
    @(posedge clk);
    h = hys_of(hyst_sel);
    o = m_ovr; u = m_und; c = m_crt;
    if (v) begin
      o = (t > HI)   ? 1'b1 : ((t < HI - h)   ? 1'b0 : m_ovr);
      u = (t < LO)   ? 1'b1 : ((t > LO + h)   ? 1'b0 : m_und);
      c = (t > CRIT) ? 1'b1 : ((t < CRIT - h) ? 1'b0 : m_crt);
    end
    wo = v && win_en && (o || u);
    p  = (mode_sel == 2'b00) && ((m_pend && !clr) || wo);
    m_ovr = o; m_und = u; m_crt = c; m_pend = p;
    @(negedge clk);
    smp_valid = 1'b0;
    sw_clr    = 1'b0;
    check(tag, event_n, exp_line());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; smp_valid = 1'b0; sw_clr = 1'b0; smp_temp = '0;
    lim_hi = W'(HI); lim_lo = W'(LO); lim_crit = W'(CRIT);
    hyst_sel = 2'd0; mode_sel = 2'b01; win_en = 1'b1; evt_en = 1'b1;
    m_ovr = 0; m_und = 0; m_crt = 0; m_pend = 0;
    repeat (3) @(negedge clk);
    check("R1 in reset", event_n, 1'b1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after reset", event_n, 1'b1);

    // R2 R3 R4 R5 R6 R7: full up/down ramps, all modes and hysteresis codes
    for (int md = 0; md < 4; md++) begin
      for (int hc = 0; hc < 4; hc++) begin
        mode_sel = 2'(md);
        hyst_sel = 2'(hc);
        for (int i = 0; i < 1024; i++) begin
          int t;
          bit clr;
          t   = (i < 512) ? (i - 256) : (767 - i);
          clr = (i % 37) == 0;
          step(1'b1, t, clr, "R2/R3/R4/R5/R6/R7 sweep");
          if ((i % 53) == 0) step(1'b0, t, 1'b1, "R5 clear-only / R4 R7 clear ignored");
        end
      end
    end

    // R6: window disabled in comparator mode matches critical-only behaviour
    mode_sel = 2'b01; hyst_sel = 2'd1; win_en = 1'b0;
    step(1'b1, 120, 1'b0, "R6 window off, over hi");
    step(1'b1, -200, 1'b0, "R6 window off, under lo");
    win_en = 1'b1;
    step(1'b1, 0, 1'b0, "R4 back inside");

    // R5: set and clear in the same cycle leaves latch set
    mode_sel = 2'b00; hyst_sel = 2'd0;
    step(1'b0, 0, 1'b0, "R5 idle");
    step(1'b1, 100, 1'b1, "R5 set wins over clear");
    step(1'b0, 0, 1'b0, "R5 held");
    step(1'b1, 0, 1'b0, "R5 held inside window");
    step(1'b0, 0, 1'b1, "R5 cleared");
    check("R5 line released", event_n, 1'b1);

    // R7 R8: lock kept while output gated off
    mode_sel = 2'b01; hyst_sel = 2'd2;
    step(1'b1, 200, 1'b0, "R7 lock set");
    check("R7 lock drives line", event_n, 1'b0);
    evt_en = 1'b0;
    step(1'b0, 200, 1'b0, "R8 gated off");
    step(1'b1, 150, 1'b1, "R8 gated, lock holds in band");
    evt_en = 1'b1;
    step(1'b0, 150, 1'b0, "R8 lock visible again");
    check("R8 lock not erased", event_n, 1'b0);

    // R9: input moves without strobe
    step(1'b1, 0, 1'b0, "R7 lock released below band");
    step(1'b0, 250, 1'b0, "R9 no strobe, high input");
    step(1'b0, -250, 1'b0, "R9 no strobe, low input");
    check("R9 line unchanged", event_n, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule